// File: doc/BRIEF.md
# SDRAM Refresh and Self-Refresh Sequencer

This block sits on the controller side of an SDRAM interface. Its only job is to keep the stored data valid. A free-running interval timer raises one refresh demand per period, and a saturating counter holds any demands that are not yet served. When demands are waiting, the block asks the bus arbiter for the command bus. Once the bus is granted and the banks report idle, it drives one auto refresh command and then holds NOPs for the refresh recovery time.

A self-refresh request takes the same grant path. It drives the self-refresh command with the clock enable low and keeps the clock enable low until the request is withdrawn. It then raises the clock enable and waits one recovery time. If the wake-up burst option is selected, it then issues a fixed number of refreshes back to back, each one recovery time after the previous one. The command bus stays requested until every sequence has fully recovered.

Top module: `sdram_refresh_seq`

## Requirements
- R1: During and directly after reset, cke_o is 1, the command is NOP ({cs_n,ras_n,cas_n,we_n} = 4'b0111) and req_o is 0.
- R2: An auto refresh is {cs_n,ras_n,cas_n,we_n} = 4'b0001 with cke_o high in that cycle and in the previous one. Outside a wake-up burst, it is driven only in the cycle after one where req_o, grant_i and banks_idle_i were all high.
- R3: After any refresh, no command other than NOP is driven for T_RFC cycles counted from the refresh cycle.
- R4: A refresh demand is raised every REF_INTERVAL cycles. With the bus freely granted, successive rising edges of req_o are exactly REF_INTERVAL cycles apart.
- R5: Demands not served because the grant is withheld are kept and served later, one refresh each, up to PEND_MAX. Further demands are dropped.
- R6: A self-refresh request takes priority over waiting refreshes. Entry is {cs_n,ras_n,cas_n,we_n} = 4'b0001 with cke_o low, and it discards all waiting refresh demands.
- R7: While in self refresh, cke_o stays low and NOP is driven until sr_req_i is released.
- R8: On exit, cke_o rises and only NOPs are driven for T_RFC cycles. The first command can come no earlier than T_RFC cycles after the rise.
- R9: If exit_burst_i is high at the end of the exit recovery, exactly BURST_COUNT refreshes follow, the first T_RFC cycles after cke_o rises and each following one exactly T_RFC cycles later. Otherwise the block returns to idle without a refresh.
- R10: req_o stays high from the request until the recovery that follows ends. A single granted refresh holds req_o for T_RFC+1 cycles.
- R11: The interval timer is held during self refresh and the wake-up burst. The next req_o rise comes exactly REF_INTERVAL+1 cycles after the block returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| banks_idle_i | input | 1 | All banks precharged and idle |
| grant_i | input | 1 | Command bus granted to this block |
| sr_req_i | input | 1 | Enter self refresh while high; release to exit |
| exit_burst_i | input | 1 | Issue a refresh burst after self-refresh exit |
| req_o | output | 1 | Command bus request |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| cke_o | output | 1 | Clock enable |

## Verification
If the recovery counter is corrupted, it shows up within T_RFC cycles of a refresh or of the clock-enable rise, as a refresh that comes too early or a burst with wrong spacing. If the pending counter is wrong, one interval later the number of refreshes served after a withheld grant differs from the number of ticks that passed. If the timer hold is wrong, the period of req_o changes, or the first request after wake-up does not land on its exact cycle. A stuck state shows immediately as req_o or cke_o failing to return to its idle level.

// File: rtl/sdram_ref_pkg.sv
package sdram_ref_pkg;
  // {cs_n, ras_n, cas_n, we_n}
  localparam logic [3:0] CMD_NOP = 4'b0111;
  localparam logic [3:0] CMD_REF = 4'b0001;

  typedef enum logic [2:0] {
    S_IDLE,
    S_REQ,
    S_ARF,
    S_RECOV,
    S_SR_ENT,
    S_SELF,
    S_SR_EXIT
  } seq_state_e;
endpackage

// File: rtl/ref_interval_timer.sv
module ref_interval_timer #(
  parameter int unsigned INTERVAL = 1560
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hold_i,
  output logic tick_o
);
  localparam int unsigned W = $clog2(INTERVAL);
  localparam logic [W-1:0] LAST = W'(INTERVAL - 1);

  logic [W-1:0] cnt_q;

  assign tick_o = !hold_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (hold_i || tick_o)  cnt_q <= '0;
    else                        cnt_q <= cnt_q + W'(1);
  end

  assert_tick_spaced_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);

  assert_hold_restarts_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> !tick_o);
endmodule

// File: rtl/ref_pending_ctr.sv
module ref_pending_ctr #(
  parameter int unsigned PEND_MAX = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic inc_i,
  input  logic dec_i,
  input  logic clr_i,
  output logic nz_o
);
  localparam int unsigned W = $clog2(PEND_MAX + 1);
  localparam logic [W-1:0] TOP = W'(PEND_MAX);

  logic [W-1:0] cnt_q;

  assign nz_o = (cnt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              cnt_q <= '0;
    else if (clr_i)                           cnt_q <= '0;
    else if (inc_i && !dec_i && cnt_q != TOP) cnt_q <= cnt_q + W'(1);
    else if (dec_i && !inc_i && cnt_q != '0)  cnt_q <= cnt_q - W'(1);
  end

  assert_pend_saturate_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !dec_i && !clr_i && cnt_q == TOP) |=> (cnt_q == TOP));

  assert_pend_keeps_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !dec_i && !clr_i && cnt_q != TOP) |=> (cnt_q == $past(cnt_q) + W'(1)));
endmodule

// File: rtl/ref_seq_fsm.sv
module ref_seq_fsm
  import sdram_ref_pkg::*;
#(
  parameter int unsigned T_RFC       = 7,
  parameter int unsigned BURST_COUNT = 4096
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       banks_idle_i,
  input  logic       grant_i,
  input  logic       sr_req_i,
  input  logic       exit_burst_i,
  input  logic       pend_nz_i,
  output logic       req_o,
  output logic [3:0] cmd_o,
  output logic       cke_o,
  output logic       dec_o,
  output logic       clr_o,
  output logic       hold_o
);
  localparam int unsigned CW = $clog2(T_RFC + 1);
  localparam int unsigned BW = $clog2(BURST_COUNT + 1);
  localparam logic [CW-1:0] RFC_LAST = CW'(T_RFC - 1);
  localparam logic [CW-1:0] RFC_GAP  = CW'(T_RFC - 2);
  localparam logic [BW-1:0] BURST_N  = BW'(BURST_COUNT);

  seq_state_e      state_q, state_d;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic [BW-1:0]   left_q, left_d;
  logic            burst_q, burst_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    left_d  = left_q;
    burst_d = burst_q;
    unique case (state_q)
      S_IDLE: if (sr_req_i || pend_nz_i) state_d = S_REQ;
      S_REQ: begin
        if (grant_i && banks_idle_i) begin
          if (sr_req_i)       state_d = S_SR_ENT;
          else if (pend_nz_i) state_d = S_ARF;
          else                state_d = S_IDLE;
        end else if (!sr_req_i && !pend_nz_i) begin
          state_d = S_IDLE;
        end
      end
      S_ARF: begin
        state_d = S_RECOV;
        cnt_d   = RFC_GAP;
        if (burst_q) left_d = left_q - BW'(1);
      end
      S_RECOV: begin
        if (cnt_q == '0) begin
          if (burst_q && left_q != '0) begin
            state_d = S_ARF;
          end else begin
            state_d = S_IDLE;
            burst_d = 1'b0;
          end
        end else begin
          cnt_d = cnt_q - CW'(1);
        end
      end
      S_SR_ENT: state_d = S_SELF;
      S_SELF: begin
        if (!sr_req_i) begin
          state_d = S_SR_EXIT;
          cnt_d   = RFC_LAST;
        end
      end
      S_SR_EXIT: begin
        if (cnt_q == '0) begin
          if (exit_burst_i) begin
            state_d = S_ARF;
            burst_d = 1'b1;
            left_d  = BURST_N;
          end else begin
            state_d = S_IDLE;
          end
        end else begin
          cnt_d = cnt_q - CW'(1);
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
      left_q  <= '0;
      burst_q <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      left_q  <= left_d;
      burst_q <= burst_d;
    end
  end

  assign req_o  = (state_q != S_IDLE);
  assign cmd_o  = (state_q == S_ARF || state_q == S_SR_ENT) ? CMD_REF : CMD_NOP;
  assign cke_o  = !(state_q == S_SR_ENT || state_q == S_SELF);
  assign dec_o  = (state_q == S_ARF) && !burst_q;
  assign clr_o  = (state_q == S_SR_ENT);
  assign hold_o = burst_q || state_q == S_SR_ENT || state_q == S_SELF
                  || state_q == S_SR_EXIT;

  assert_ref_cke_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == CMD_REF && cke_o) |-> $past(cke_o));

  assert_ref_granted_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == CMD_REF && cke_o && !burst_q) |-> $past(grant_i && banks_idle_i && req_o));

  assert_nop_after_ref_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == CMD_REF && cke_o) |=> (cmd_o == CMD_NOP));

  assert_sr_entry_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cke_o) |-> (cmd_o == CMD_REF));

  assert_self_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cke_o && $past(!cke_o)) |-> (cmd_o == CMD_NOP && req_o));

  assert_exit_nop_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cke_o) |-> (cmd_o == CMD_NOP));
endmodule

// File: rtl/sdram_refresh_seq.sv
module sdram_refresh_seq #(
  parameter int unsigned REF_INTERVAL = 1560,
  parameter int unsigned T_RFC        = 7,
  parameter int unsigned BURST_COUNT  = 4096,
  parameter int unsigned PEND_MAX     = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic banks_idle_i,
  input  logic grant_i,
  input  logic sr_req_i,
  input  logic exit_burst_i,
  output logic req_o,
  output logic cs_n_o,
  output logic ras_n_o,
  output logic cas_n_o,
  output logic we_n_o,
  output logic cke_o
);
  logic       tick, hold, pend_nz, dec, clr;
  logic [3:0] cmd;

  ref_interval_timer #(.INTERVAL(REF_INTERVAL)) i_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hold_i (hold),
    .tick_o (tick)
  );

  ref_pending_ctr #(.PEND_MAX(PEND_MAX)) i_pend (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (tick),
    .dec_i  (dec),
    .clr_i  (clr),
    .nz_o   (pend_nz)
  );

  ref_seq_fsm #(.T_RFC(T_RFC), .BURST_COUNT(BURST_COUNT)) i_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .banks_idle_i (banks_idle_i),
    .grant_i      (grant_i),
    .sr_req_i     (sr_req_i),
    .exit_burst_i (exit_burst_i),
    .pend_nz_i    (pend_nz),
    .req_o        (req_o),
    .cmd_o        (cmd),
    .cke_o        (cke_o),
    .dec_o        (dec),
    .clr_o        (clr),
    .hold_o       (hold)
  );

  assign {cs_n_o, ras_n_o, cas_n_o, we_n_o} = cmd;
endmodule

// File: tb/test_sdram_refresh_seq.sv
module test_sdram_refresh_seq;
  localparam int REF_INTERVAL = 40;
  localparam int T_RFC        = 5;
  localparam int BURST_COUNT  = 6;
  localparam int PEND_MAX     = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic banks_idle = 1'b1, grant = 1'b0, sr_req = 1'b0, exit_burst = 1'b0;
  logic req, cs_n, ras_n, cas_n, we_n, cke;

  int n_tests = 0, n_fail = 0, cyc = 0;
  int n_ref = 0, n_sref = 0, last_ref = 0, last_rise = 0;
  bit have_ref = 0, have_rise = 0, prev_cke = 1, prev_ok = 0;
  bit allow = 1, rnd_mode = 0, burst_flag = 0;

  always #2 clk = ~clk;

  sdram_refresh_seq #(
    .REF_INTERVAL(REF_INTERVAL), .T_RFC(T_RFC),
    .BURST_COUNT(BURST_COUNT), .PEND_MAX(PEND_MAX)
  ) i_sdram_refresh_seq (
    .clk_i(clk), .rst_ni(rst_n), .banks_idle_i(banks_idle), .grant_i(grant),
    .sr_req_i(sr_req), .exit_burst_i(exit_burst), .req_o(req),
    .cs_n_o(cs_n), .ras_n_o(ras_n), .cas_n_o(cas_n), .we_n_o(we_n), .cke_o(cke)
  );

  function automatic int exp_refs(input int cycles);
    return cycles / REF_INTERVAL;
  endfunction

  function automatic int exp_burst_at(input int rise, input int k);
    return rise + T_RFC * (k + 1);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc     <= cyc + 1;
    prev_ok <= req && grant && banks_idle;
  end

  // arbiter model
  always @(negedge clk) begin
    if (rnd_mode) allow = ($urandom % 10) < 7;
    grant = allow && req;
  end

  // bus monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (!cs_n && {ras_n, cas_n, we_n} != 3'b111) begin
        if (cke) begin
          n_ref++;
          chk(prev_cke, "R2 cke high before refresh", prev_cke, 1);
          chk({cs_n, ras_n, cas_n, we_n} == 4'b0001, "R2 refresh code",
              {cs_n, ras_n, cas_n, we_n}, 1);
          if (!burst_flag) chk(prev_ok, "R2 grant and idle before refresh", prev_ok, 1);
          if (have_ref) chk(cyc - last_ref >= T_RFC, "R3 refresh gap", cyc - last_ref, T_RFC);
          if (have_rise) chk(cyc - last_rise >= T_RFC, "R8 exit gap", cyc - last_rise, T_RFC);
          last_ref = cyc;
          have_ref = 1;
        end else if (prev_cke) begin
          n_sref++;
          if (have_ref) chk(cyc - last_ref >= T_RFC, "R3 gap before self refresh",
                            cyc - last_ref, T_RFC);
        end
      end
      if (cke && !prev_cke) begin
        last_rise = cyc;
        have_rise = 1;
      end
      prev_cke = cke;
    end
  end

  task automatic wait_req(input bit lvl, output int c);
    int t = 0;
    while (req != lvl && t < 5000) begin
      @(negedge clk);
      t++;
    end
    c = cyc;
  endtask

  task automatic next_rise(output int c);
    int d;
    wait_req(1'b0, d);
    wait_req(1'b1, c);
  endtask

  task automatic wait_cke(input bit lvl, output int c);
    int t = 0;
    while (cke != lvl && t < 5000) begin
      @(negedge clk);
      t++;
    end
    c = cyc;
  endtask

  task automatic summary;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    summary();
    $finish;
  end

  initial begin
    int r0, r1, f0, n0, u, c, nb, seed;
    int at [8];
    seed = $urandom(32'd2718);

    // R1 reset state
    repeat (3) @(negedge clk);
    chk(cke == 1'b1, "R1 cke in reset", cke, 1);
    chk({cs_n, ras_n, cas_n, we_n} == 4'b0111, "R1 NOP in reset",
        {cs_n, ras_n, cas_n, we_n}, 7);
    chk(req == 1'b0, "R1 req in reset", req, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req == 1'b0 && cke, "R1 idle after reset", req, 0);

    // R4 period, R10 request width
    next_rise(r0);
    wait_req(1'b0, f0);
    wait_req(1'b1, r1);
    chk(r1 - r0 == REF_INTERVAL, "R4 request period", r1 - r0, REF_INTERVAL);
    chk(f0 - r0 == T_RFC + 1, "R10 request width", f0 - r0, T_RFC + 1);

    // R5 held demands served later
    allow = 0;
    next_rise(c);
    repeat (2 * REF_INTERVAL) @(negedge clk);
    chk(n_ref >= 0 && req, "R10 request held while not granted", req, 1);
    n0 = n_ref;
    allow = 1;
    repeat (27) @(negedge clk);
    chk(n_ref - n0 == 3, "R5 held demands served", n_ref - n0, 3);

    // R5 saturation
    allow = 0;
    next_rise(c);
    n0 = n_ref;
    repeat (4 * REF_INTERVAL) @(negedge clk);
    chk(n_ref == n0, "R2 no refresh without grant", n_ref - n0, 0);
    allow = 1;
    repeat (27) @(negedge clk);
    chk(n_ref - n0 == PEND_MAX, "R5 saturation", n_ref - n0, PEND_MAX);

    // R2 busy banks block refresh
    banks_idle = 0;
    next_rise(c);
    n0 = n_ref;
    repeat (45) @(negedge clk);
    chk(n_ref == n0, "R2 no refresh with busy banks", n_ref - n0, 0);
    banks_idle = 1;
    repeat (25) @(negedge clk);
    chk(n_ref - n0 == 2, "R2 refresh after banks idle", n_ref - n0, 2);

    // R6..R9, R11 self refresh with wake-up burst
    wait_req(1'b0, c);
    burst_flag = 1;
    exit_burst = 1;
    n0 = n_ref;
    sr_req = 1;
    wait_cke(1'b0, c);
    chk({cs_n, ras_n, cas_n, we_n} == 4'b0001, "R6 self refresh entry code",
        {cs_n, ras_n, cas_n, we_n}, 1);
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (i % 10 == 0) begin
        chk(!cke, "R7 cke low in self refresh", cke, 0);
        chk({cs_n, ras_n, cas_n, we_n} == 4'b0111, "R7 NOP in self refresh",
            {cs_n, ras_n, cas_n, we_n}, 7);
      end
    end
    chk(n_ref == n0, "R7 no refresh during self refresh", n_ref - n0, 0);
    sr_req = 0;
    wait_cke(1'b1, u);
    chk({cs_n, ras_n, cas_n, we_n} == 4'b0111, "R8 NOP at exit",
        {cs_n, ras_n, cas_n, we_n}, 7);
    nb = 0;
    for (int i = 1; i <= T_RFC * (BURST_COUNT + 1) + 3; i++) begin
      @(negedge clk);
      if (cke && {cs_n, ras_n, cas_n, we_n} == 4'b0001 && nb < 8) begin
        at[nb] = cyc;
        nb++;
      end
    end
    chk(nb == BURST_COUNT, "R9 burst length", nb, BURST_COUNT);
    chk(at[0] == exp_burst_at(u, 0), "R8 first command after exit", at[0] - u, T_RFC);
    for (int k = 1; k < BURST_COUNT && k < nb; k++)
      chk(at[k] == exp_burst_at(u, k), "R9 burst spacing", at[k] - at[k-1], T_RFC);
    burst_flag = 0;
    wait_req(1'b1, c);
    chk(c == exp_burst_at(u, BURST_COUNT) + REF_INTERVAL + 1, "R11 timer restart after burst",
        c - u, T_RFC * (BURST_COUNT + 1) + REF_INTERVAL + 1);

    // R6 priority and clearing, R9 no burst
    exit_burst = 0;
    allow = 0;
    next_rise(c);
    n0 = n_ref;
    sr_req = 1;
    allow = 1;
    wait_cke(1'b0, c);
    chk(n_ref == n0, "R6 self refresh before waiting refresh", n_ref - n0, 0);
    repeat (10) @(negedge clk);
    sr_req = 0;
    wait_cke(1'b1, u);
    wait_req(1'b0, c);
    chk(c == u + T_RFC, "R8 exit recovery length", c - u, T_RFC);
    wait_req(1'b1, c);
    chk(c == u + T_RFC + REF_INTERVAL + 1, "R11 timer restart after exit",
        c - u, T_RFC + REF_INTERVAL + 1);
    chk(n_ref == n0, "R9 no refresh without burst, R6 demands dropped", n_ref - n0, 0);

    // random grant and bank activity
    wait_req(1'b0, c);
    n0 = n_ref;
    rnd_mode = 1;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      banks_idle = ($urandom % 10) < 8;
    end
    rnd_mode = 0;
    allow = 1;
    banks_idle = 1;
    repeat (100) @(negedge clk);
    c = n_ref - n0;
    chk(c >= exp_refs(2100) - 2 && c <= exp_refs(2100) + 2, "R5 refresh count under random stalls",
        c, exp_refs(2100));
    chk(n_sref == 2, "R6 self refresh entries", n_sref, 2);

    summary();
    $finish;
  end
endmodule